// File: doc/BRIEF.md
# Periodic Row Refresh Sequencer for Multiplexed-Address DRAM

This block keeps a bank-organised array of 64K-by-1 dynamic memories alive by refreshing one row at a time. A free-running interval timer raises a refresh request once per period. The block then asks for the memory bus with a request/grant handshake, much like a DMA channel doing a transfer that moves no data. Once granted, it puts an 8-bit row number on the multiplexed address lines and strobes the row strobe low on every bank together. The column strobes and write enable stay inactive throughout. When the strobe ends, the block gives the bus back and steps the row number, so 256 requests cover the whole array.

The refresh period and the row-strobe low width are given in nanoseconds together with the clock period, and are converted to clock counts. The defaults are a 15 us period and a 200 ns strobe at 50 MHz, which is 750 and 10 cycles. A full pass over the 256 rows then takes 3.84 ms, inside a 4 ms retention limit. If the bus grant comes late, the request is held. Timer periods that expire while a request is already pending merge into it. The address is driven for one full cycle before the strobe falls, and it is released in the cycle the strobe rises.

Top module: `ras_refresh_ctrl`

## Requirements
- R1: With no grant delay beyond the slack in one period, successive rising edges of `busReq` are exactly `INTERVAL_CYCLES` clocks apart (750 by default, 40 in the bench configuration).
- R2: `busReq` goes high for a pending refresh and stays high until `busGrant` is seen. No row strobe is driven and the address bus stays released before the grant.
- R3: At most one refresh is pending. After a long grant stall, exactly one refresh runs at once, and the next one waits for a fresh timer period.
- R4: `addrOe` is high with the row number on `addrOut` for one cycle before the strobe falls. The address equals that value at the fall and stays driven while the strobe is low.
- R5: All bits of `rasN` fall and rise together. Each strobe stays low for exactly `RAS_CYCLES` clocks (10 by default, 4 in the bench configuration).
- R6: `casN` is all ones and `weN` is one at all times.
- R7: In the cycle where the strobe returns high, `addrOe` and `busReq` are both low.
- R8: The first refresh after reset uses row 0. Each later refresh uses the previous row plus one, and row 255 is followed by row 0.
- R9: `passDone` is high for exactly one cycle, in the cycle where the strobe for row 255 ends, and at no other time.
- R10: While `rstN` is low, `busReq`, `addrOe` and `passDone` are 0, `addrOut` is 0, and `rasN` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Bus granted to the refresh sequencer |
| busReq | output | 1 | Bus request, held from request until release |
| addrOut | output | ROW_BITS (8) | Row address onto the multiplexed address lines |
| addrOe | output | 1 | Address drive enable |
| rasN | output | NUM_BANKS (4) | Active-low row strobe, one per bank |
| casN | output | NUM_BANKS (4) | Active-low column strobe, one per bank, held inactive |
| weN | output | 1 | Active-low write enable, held inactive |
| passDone | output | 1 | One-cycle pulse at the end of each 256-row pass |

## Verification
The bench varies the grant latency at random for each request. A timer that restarted on the grant, instead of running freely, would let the request spacing drift with that latency. A long grant stall then checks the pending-request queue. A design that queued every missed period would fire back-to-back strobes right after the grant, instead of waiting for the next period. Two full passes exercise the 255-to-0 wrap and the end-of-pass pulse. A counter that stuck at one value, skipped rows or failed to wrap, or a pulse that was mistimed, would show up as a wrong address at a strobe fall or a misplaced `passDone`. Each strobe is also checked for its setup cycle, its exact width, all banks moving together, and the release of the address in the cycle the strobe rises.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_SETUP = 2'd2,
    ST_RAS   = 2'd3
  } refState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic acceptReq;   // grant taken, clear the pending flag
    logic loadRasCnt;  // start timing the strobe width
    logic advanceRow;  // strobe finished, step the row
  } ctlStrobes_t;

  // Status from the datapath back to the sequencer
  typedef struct packed {
    logic pending;     // a refresh is waiting
    logic rasLast;     // last cycle of the strobe width
  } dpStatus_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int INTERVAL_CYCLES = 750,
  parameter int RAS_CYCLES      = 10,
  parameter int ROW_BITS        = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  output dpStatus_t           status,
  output logic [ROW_BITS-1:0] rowAddr,
  output logic                passDone
);

  localparam int IW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam int RW = (RAS_CYCLES > 1) ? $clog2(RAS_CYCLES) : 1;
  localparam logic [IW-1:0] INT_LAST = IW'(INTERVAL_CYCLES - 1);
  localparam logic [RW-1:0] RAS_LOAD = RW'(RAS_CYCLES - 1);
  localparam logic [ROW_BITS-1:0] ROW_MAX = '1;

  logic [IW-1:0] intervalCnt;
  logic          periodTick;
  logic          pendingQ;
  logic [RW-1:0] rasCnt;
  logic [ROW_BITS-1:0] rowQ;
  logic          passQ;

  // Free-running period timer: it never waits for the bus
  assign periodTick = (intervalCnt == INT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (periodTick) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  // Single pending flag; a new tick wins over a same-cycle accept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (periodTick) begin
      pendingQ <= 1'b1;
    end else if (strobes.acceptReq) begin
      pendingQ <= 1'b0;
    end
  end

  // Strobe width down-counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasCnt <= '0;
    end else if (strobes.loadRasCnt) begin
      rasCnt <= RAS_LOAD;
    end else if (rasCnt != '0) begin
      rasCnt <= rasCnt - 1'b1;
    end
  end

  // Row counter and end-of-pass pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ  <= '0;
      passQ <= 1'b0;
    end else begin
      passQ <= strobes.advanceRow && (rowQ == ROW_MAX);
      if (strobes.advanceRow) begin
        rowQ <= rowQ + 1'b1;
      end
    end
  end

  assign status.pending = pendingQ;
  assign status.rasLast = (rasCnt == '0);
  assign rowAddr        = rowQ;
  assign passDone       = passQ;

  AST_TICK_SETS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    periodTick |=> pendingQ); // R1
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !strobes.acceptReq) |=> pendingQ); // R3
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advanceRow |=> (rowQ == $past(rowQ) + 1'b1)); // R8
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advanceRow |=> $stable(rowQ)); // R8
  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    passQ |=> !passQ); // R9

endmodule

// File: rtl/refresh_ctl.sv
module refresh_ctl
  import refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busGrant,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        busReq,
  output logic        addrOe,
  output logic        rasActive
);

  refState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (status.pending) nextState = ST_REQ;
      end
      ST_REQ: begin
        if (busGrant) begin
          strobes.acceptReq = 1'b1;
          nextState = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strobes.loadRasCnt = 1'b1;
        nextState = ST_RAS;
      end
      ST_RAS: begin
        if (status.rasLast) begin
          strobes.advanceRow = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busReq    = (state != ST_IDLE);
  assign addrOe    = (state == ST_SETUP) || (state == ST_RAS);
  assign rasActive = (state == ST_RAS);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !addrOe && !busGrant) |=> (busReq && !rasActive)); // R2
  AST_SETUP_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrOe) |-> !rasActive); // R4
  AST_OE_COVERS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    rasActive |-> addrOe); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasActive) |-> (!addrOe && !busReq)); // R7

endmodule

// File: rtl/ras_refresh_ctrl.sv
module ras_refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int CLK_PERIOD_NS     = 20,
  parameter int REFRESH_PERIOD_NS = 15000,
  parameter int RAS_WIDTH_NS      = 200,
  parameter int ROW_BITS          = 8,
  parameter int NUM_BANKS         = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busGrant,
  output logic                 busReq,
  output logic [ROW_BITS-1:0]  addrOut,
  output logic                 addrOe,
  output logic [NUM_BANKS-1:0] rasN,
  output logic [NUM_BANKS-1:0] casN,
  output logic                 weN,
  output logic                 passDone
);

  localparam int INTERVAL_CYCLES = REFRESH_PERIOD_NS / CLK_PERIOD_NS;
  localparam int RAS_CYCLES = (RAS_WIDTH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  ctlStrobes_t strobes;
  dpStatus_t   status;
  logic [ROW_BITS-1:0] rowAddr;
  logic rasActive;

  refresh_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busGrant  (busGrant),
    .status    (status),
    .strobes   (strobes),
    .busReq    (busReq),
    .addrOe    (addrOe),
    .rasActive (rasActive)
  );

  refresh_dp #(
    .INTERVAL_CYCLES (INTERVAL_CYCLES),
    .RAS_CYCLES      (RAS_CYCLES),
    .ROW_BITS        (ROW_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .status   (status),
    .rowAddr  (rowAddr),
    .passDone (passDone)
  );

  assign addrOut = addrOe ? rowAddr : '0;
  assign weN     = 1'b1;

  // One row strobe per bank, all from the same source; column strobes idle
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rasN[b] = ~rasActive;
    assign casN[b] = 1'b1;
  end

  AST_BANKS_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (rasN == '0) || (rasN == '1)); // R5
  AST_CAS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (casN == '1) && weN); // R6
  AST_NO_RAS_UNDRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (rasN == '0) |-> addrOe); // R4

endmodule

// File: tb/ras_refresh_ctrl_tb.sv
module ras_refresh_ctrl_tb;

  localparam int CLKNS = 20;
  localparam int IVL   = 40;   // 800 ns / 20 ns
  localparam int RASW  = 4;    // 80 ns / 20 ns
  localparam int NB    = 4;
  localparam int RB    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b0;
  logic busReq, addrOe, weN, passDone;
  logic [RB-1:0] addrOut;
  logic [NB-1:0] rasN, casN;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLKNS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ras_refresh_ctrl #(
    .CLK_PERIOD_NS (CLKNS), .REFRESH_PERIOD_NS (IVL*CLKNS),
    .RAS_WIDTH_NS (RASW*CLKNS), .ROW_BITS (RB), .NUM_BANKS (NB)
  ) u_dut (
    .clk (clk), .rstN (rstN), .busGrant (busGrant), .busReq (busReq),
    .addrOut (addrOut), .addrOe (addrOe), .rasN (rasN), .casN (casN),
    .weN (weN), .passDone (passDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic int nextRow(input int r);
    return (r + 1) % 256;
  endfunction

  // Monitor and grant driver state
  bit stall = 0;
  int expRow = 0, lastRow = -1;
  int falls = 0, passes = 0, stallFalls = 0;
  int lastReqRise = -1, lastFall = -1, prevFall = -1;
  int lowWidth = 0, latLeft = 0;
  bit prevRasLow = 0, prevOe = 0, prevReq = 0, prevPass = 0;
  logic [RB-1:0] prevAddr = '0;

  initial begin
    void'($urandom(32'h5eed_1234));
    forever begin
      @(negedge clk);
      if (rstN) begin
        bit rasLow;
        check(casN == '1 && weN, "R6", {casN, weN}, 5'h1f);
        check(rasN == '0 || rasN == '1, "R5", rasN, 0);
        rasLow = (rasN == '0);
        if (busReq && !prevReq) begin
          if (lastReqRise >= 0)
            check(cyc - lastReqRise == IVL, "R1", cyc - lastReqRise, IVL);
          lastReqRise = cyc;
          latLeft = $urandom_range(7, 0);
        end
        if (rasLow && !prevRasLow) begin
          check(prevOe && prevAddr == addrOut, "R4", prevAddr, addrOut);
          check(addrOe && addrOut == RB'(expRow), "R8", addrOut, expRow);
          check(busReq && busGrant, "R2", {busReq, busGrant}, 3);
          if (stall) stallFalls++;
          lastRow = expRow;
          expRow = nextRow(expRow);
          falls++;
          prevFall = lastFall;
          lastFall = cyc;
          lowWidth = 0;
        end
        if (rasLow) begin
          lowWidth++;
          if (!addrOe) check(0, "R4", addrOe, 1);
        end
        if (!rasLow && prevRasLow) begin
          check(lowWidth == RASW, "R5", lowWidth, RASW);
          check(!addrOe && !busReq, "R7", {addrOe, busReq}, 0);
          check(passDone == (lastRow == 255), "R9", passDone, lastRow == 255);
        end else if (passDone) begin
          check(0, "R9", passDone, 0);
        end
        if (passDone) begin
          passes++;
          check(!prevPass, "R9", prevPass, 0);
        end
        if (!busReq || addrOe) begin
          // nothing held
        end else if (prevReq && !rasLow) begin
          check(!addrOe, "R2", addrOe, 0);
        end
        prevRasLow = rasLow; prevOe = addrOe; prevAddr = addrOut;
        prevReq = busReq; prevPass = passDone;
        // Grant driver
        if (!busReq) busGrant = 1'b0;
        else if (stall) busGrant = 1'b0;
        else if (!busGrant) begin
          if (latLeft == 0) busGrant = 1'b1;
          else latLeft--;
        end
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc > 60000);
    if (!done) begin
      check(0, "WATCHDOG", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!busReq && !addrOe && !passDone && addrOut == '0 && rasN == '1,
            "R10", {busReq, addrOe, passDone, rasN}, 4'hf);
    end
    rstN = 1'b1;
    // Two full passes with random grant latency (R1, R5, R8, R9)
    wait (falls >= 2*256 + 4);
    check(passes == 2, "R9", passes, 2);
    // R3: stall the grant over several periods right after a strobe fall
    @(negedge clk);
    wait (prevRasLow == 0);
    begin
      int tickRef;
      tickRef = lastReqRise - 2;
      stall = 1;
      while (cyc < tickRef + 4*IVL + 10) @(negedge clk);
      check(stallFalls == 0, "R2", stallFalls, 0);
      check(busReq, "R2", busReq, 1);
      latLeft = 0;
      lastReqRise = -1;
      stall = 0;
      begin
        int f0;
        f0 = falls;
        wait (falls == f0 + 2);
        check(lastFall - prevFall > RASW + 10, "R3", lastFall - prevFall, IVL - 8);
      end
    end
    // Further random traffic after the stall (R1 spacing restarts)
    wait (falls >= 2*256 + 30);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule